// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Sequencer

This block drives a single-operand unit (a move, a sign extension or a similar one-input operation) through a loop over vector elements. It keeps two element indices: one on the source side and one on the destination side. Each index is steered by its own predicate mask. On every active cycle the block issues one pair of register numbers: the source register to read and the destination register to write. The single-operand unit lies outside the block.

The source index follows the set bits of the source mask, and the destination index follows the set bits of the destination mask. Because the two indices move independently, one pass packs the selected source elements and spreads them into the selected destination slots.

The masks and the scalar/vector tags pick the familiar forms:
- **Compress:** the destination mask is all ones.
- **Expand:** the source mask is all ones.
- **Splat:** the source is scalar, the destination is a vector and the masks are all ones.
- **Insert:** the source is scalar and the destination mask has a single bit set.
- **Select:** the source is a vector, its mask has a single bit set and the destination is scalar.

Each mask scan is a priority encoder. A transfer therefore costs one cycle however many clear mask bits it skips.

Top module: `twin_pred_seq`

## Requirements
- R1: After synchronous reset, `busy`, `issue_valid` and `done` are low and `xfer_count` is zero.
- R2: `start` while idle latches every configuration input and clears `xfer_count`. `busy` is high from the next cycle. `start` while busy is ignored and has no effect on the running operation.
- R3: With a vector source, each transfer uses the lowest source element index that meets three conditions: it is at or above the current source index, it is below VL, and its `src_mask` bit is set (bit i belongs to element i). `issue_src_reg` is `src_base` plus that index, modulo 2^REG_W.
- R4: With a vector destination, each transfer uses the lowest destination index chosen the same way from `dst_mask`. `issue_dst_reg` is `dst_base` plus that index, modulo 2^REG_W.
- R5: With a scalar source, every transfer reads `src_base`, and `src_mask` is not consulted.
- R6: With a scalar destination, every transfer writes `dst_base`, and `dst_mask` is not consulted. The operation ends after its first transfer, and `done` is raised in the same cycle as that transfer.
- R7: After a transfer, a vector index moves to one past the element it just used. A scalar index stays at zero.
- R8: The operation ends when an index has reached VL, or when a vector mask has no set bit left below VL. It then pulses `done` for one cycle with no transfer in that cycle. VL = 0 gives no transfer.
- R9: Transfers occur on consecutive cycles starting the cycle after the `start` edge, one per cycle, with no idle cycle between them.
- R10: `xfer_count` equals the number of transfers issued since the last accepted `start`, and it holds that value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| vl | input | IW | Vector length, 0 to MAX_VL |
| src_mask | input | MAX_VL | Source predicate, bit i for element i |
| dst_mask | input | MAX_VL | Destination predicate, bit i for element i |
| src_vec | input | 1 | Source is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or scalar (0) |
| src_base | input | REG_W | First source register number |
| dst_base | input | REG_W | First destination register number |
| busy | output | 1 | Operation in progress |
| issue_valid | output | 1 | A transfer pair is presented this cycle |
| issue_src_reg | output | REG_W | Source register for this transfer |
| issue_dst_reg | output | REG_W | Destination register for this transfer |
| done | output | 1 | One-cycle pulse at the end of an operation |
| xfer_count | output | IW | Transfers issued in the current or last operation |

## Verification
Directed cases cover the following patterns, and each one isolates a different rule:
- **Pure compress** (sparse source mask): shows the source scan skipping clear bits while the destination index fills slots densely.
- **Pure expand:** shows the same behaviour with the roles of the two indices swapped.
- **Splat and insert:** show that a scalar source stays fixed.
- **Select:** shows that a scalar destination stops the loop after one transfer.
- **Zero VL and an empty source mask:** separate the two ways the loop can end without a transfer.
- **Base near the top of the register space:** checks register-number wrap.
- **Start pulse during a run:** shows it is ignored.

Seeded random masks (dense, sparse, single-bit and arbitrary) with random tags and VL are compared against a bench model, pair by pair and cycle by cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tps_state_e;
endpackage

// File: rtl/tps_scan.sv
// Finds the next usable element for one operand side.
// Vector: lowest set mask bit at or above from_idx and below vl.
// Scalar: from_idx itself, usable while below vl.
module tps_scan #(
  parameter int N  = 16,
  parameter int IW = 5
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] from_idx,
  input  logic [IW-1:0] vl,
  input  logic          is_vec,
  output logic [IW-1:0] hit_idx,
  output logic          found
);
  always_comb begin
    hit_idx = vl;
    found   = 1'b0;
    if (!is_vec) begin
      hit_idx = from_idx;
      found   = (from_idx < vl);
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (mask[i] && (IW'(i) >= from_idx) && (IW'(i) < vl)) begin
          hit_idx = IW'(i);
          found   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int MAX_VL = 16,
  parameter int REG_W  = 7,
  localparam int IW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IW-1:0]     vl,
  input  logic [MAX_VL-1:0] src_mask,
  input  logic [MAX_VL-1:0] dst_mask,
  input  logic              src_vec,
  input  logic              dst_vec,
  input  logic [REG_W-1:0]  src_base,
  input  logic [REG_W-1:0]  dst_base,
  output logic              busy,
  output logic              issue_valid,
  output logic [REG_W-1:0]  issue_src_reg,
  output logic [REG_W-1:0]  issue_dst_reg,
  output logic              done,
  output logic [IW-1:0]     xfer_count
);
  import tps_pkg::*;

  tps_state_e        state_q;
  logic [IW-1:0]     vl_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic              sv_q, dv_q;
  logic [REG_W-1:0]  sb_q, db_q;
  logic [IW-1:0]     si_q, di_q;

  logic [IW-1:0]     s_hit, d_hit;
  logic              s_found, d_found;

  tps_scan #(.N(MAX_VL), .IW(IW)) u_src_scan (
    .mask(smask_q), .from_idx(si_q), .vl(vl_q), .is_vec(sv_q),
    .hit_idx(s_hit), .found(s_found)
  );

  tps_scan #(.N(MAX_VL), .IW(IW)) u_dst_scan (
    .mask(dmask_q), .from_idx(di_q), .vl(vl_q), .is_vec(dv_q),
    .hit_idx(d_hit), .found(d_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      busy          <= 1'b0;
      issue_valid   <= 1'b0;
      done          <= 1'b0;
      xfer_count    <= '0;
      issue_src_reg <= '0;
      issue_dst_reg <= '0;
      vl_q          <= '0;
      smask_q       <= '0;
      dmask_q       <= '0;
      sv_q          <= 1'b0;
      dv_q          <= 1'b0;
      sb_q          <= '0;
      db_q          <= '0;
      si_q          <= '0;
      di_q          <= '0;
    end else begin
      issue_valid <= 1'b0;
      done        <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            vl_q       <= vl;
            smask_q    <= src_mask;
            dmask_q    <= dst_mask;
            sv_q       <= src_vec;
            dv_q       <= dst_vec;
            sb_q       <= src_base;
            db_q       <= dst_base;
            si_q       <= '0;
            di_q       <= '0;
            xfer_count <= '0;
            busy       <= 1'b1;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!s_found || !d_found) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            issue_valid   <= 1'b1;
            issue_src_reg <= sb_q + REG_W'(s_hit);
            issue_dst_reg <= db_q + REG_W'(d_hit);
            xfer_count    <= xfer_count + 1'b1;
            if (sv_q) si_q <= s_hit + 1'b1;
            if (dv_q) begin
              di_q <= d_hit + 1'b1;
            end else begin
              done    <= 1'b1;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tps_check.sv
module tps_check #(
  parameter int MAX_VL = 16,
  parameter int REG_W  = 7,
  localparam int IW    = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              issue_valid,
  input logic [REG_W-1:0]  issue_src_reg,
  input logic [REG_W-1:0]  issue_dst_reg,
  input logic              done,
  input logic [IW-1:0]     xfer_count,
  input logic              sv_q,
  input logic              dv_q,
  input logic [MAX_VL-1:0] smask_q,
  input logic [REG_W-1:0]  sb_q,
  input logic [REG_W-1:0]  db_q
);
  logic [REG_W-1:0] src_off;
  logic             src_bit_ok;

  always_comb begin
    src_off    = issue_src_reg - sb_q;
    src_bit_ok = 1'b0;
    for (int i = 0; i < MAX_VL; i++)
      if (src_off == REG_W'(i) && smask_q[i]) src_bit_ok = 1'b1;
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r3_src_mask_bit_set: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && sv_q) |-> src_bit_ok);

  a_r5_scalar_src_fixed: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !sv_q) |-> (issue_src_reg == sb_q));

  a_r6_scalar_dst_single: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !dv_q) |-> (done && issue_dst_reg == db_q));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_issue_while_busy: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $past(busy));

  a_r10_count_steps: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (xfer_count == IW'($past(xfer_count) + 1'b1)));
endmodule

bind twin_pred_seq tps_check #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .issue_valid(issue_valid), .issue_src_reg(issue_src_reg),
  .issue_dst_reg(issue_dst_reg), .done(done), .xfer_count(xfer_count),
  .sv_q(sv_q), .dv_q(dv_q), .smask_q(smask_q), .sb_q(sb_q), .db_q(db_q)
);

// File: tb/twin_pred_seq_bench.sv
module twin_pred_seq_bench;
  localparam int N  = 16;
  localparam int RW = 7;
  localparam int IW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic [N-1:0]  src_mask = '0, dst_mask = '0;
  logic          src_vec = 1'b0, dst_vec = 1'b0;
  logic [RW-1:0] src_base = '0, dst_base = '0;
  logic          busy, issue_valid, done;
  logic [RW-1:0] issue_src_reg, issue_dst_reg;
  logic [IW-1:0] xfer_count;

  twin_pred_seq #(.MAX_VL(N), .REG_W(RW)) u_twin_pred_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_vec(src_vec), .dst_vec(dst_vec),
    .src_base(src_base), .dst_base(dst_base),
    .busy(busy), .issue_valid(issue_valid),
    .issue_src_reg(issue_src_reg), .issue_dst_reg(issue_dst_reg),
    .done(done), .xfer_count(xfer_count)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int exp_n;
  int exp_src [0:N];
  int exp_dst [0:N];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Model built from R3..R8: scan each side, transfer, step (R7), stop.
  function automatic void ref_model(int v, logic [N-1:0] sm, logic [N-1:0] dm,
                                    bit sv, bit dv, int sb, int db);
    int si = 0, di = 0, ns, nd;
    bit sok, dok;
    exp_n = 0;
    for (int guard = 0; guard <= N; guard++) begin
      sok = 0; dok = 0; ns = si; nd = di;
      if (sv) begin
        for (int i = N - 1; i >= 0; i--)
          if (sm[i] && i >= si && i < v) begin ns = i; sok = 1; end
      end else sok = (si < v);
      if (dv) begin
        for (int i = N - 1; i >= 0; i--)
          if (dm[i] && i >= di && i < v) begin nd = i; dok = 1; end
      end else dok = (di < v);
      if (!(sok && dok)) break;
      exp_src[exp_n] = (sb + ns) % (1 << RW);
      exp_dst[exp_n] = (db + nd) % (1 << RW);
      exp_n++;
      if (sv) si = ns + 1;
      if (!dv) break;
      di = nd + 1;
    end
  endfunction

  task automatic run_op(input int v, input logic [N-1:0] sm, input logic [N-1:0] dm,
                        input bit sv, input bit dv, input int sb, input int db,
                        input bit poke);
    int got = 0, cyc = 0, exp_cyc, held;
    bit fin = 0;
    ref_model(v, sm, dm, sv, dv, sb, db);
    exp_cyc = exp_n + ((dv || exp_n == 0) ? 1 : 0);
    @(negedge clk);
    vl = IW'(v); src_mask = sm; dst_mask = dm; src_vec = sv; dst_vec = dv;
    src_base = RW'(sb); dst_base = RW'(db); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin // R2: start while busy, with a different configuration
      start = 1'b1; vl = IW'(N); src_mask = '1; dst_mask = '1;
      src_vec = 1'b1; dst_vec = 1'b1; src_base = RW'(sb + 5); dst_base = RW'(db + 9);
    end
    while (!fin && cyc < 4 * N) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (issue_valid) begin
        if (got < exp_n) begin
          chk(int'(issue_src_reg) == exp_src[got], sv ? "R3 R7" : "R5",
              "source register", int'(issue_src_reg), exp_src[got]);
          chk(int'(issue_dst_reg) == exp_dst[got], dv ? "R4 R7" : "R6",
              "destination register", int'(issue_dst_reg), exp_dst[got]);
        end
        got++;
      end
      if (done) begin
        fin = 1;
        chk(!dv && got > 0 ? issue_valid : !issue_valid, dv ? "R8" : "R6",
            "transfer in done cycle", int'(issue_valid), (!dv && got > 0) ? 1 : 0);
      end
    end
    chk(fin, "R8", "done seen", int'(fin), 1);
    chk(got == exp_n, poke ? "R2" : "R8", "number of transfers", got, exp_n);
    chk(cyc == exp_cyc, "R9", "cycles start to done", cyc, exp_cyc);
    chk(int'(xfer_count) == exp_n, "R10", "xfer_count at done", int'(xfer_count), exp_n);
    held = int'(xfer_count);
    @(negedge clk);
    @(negedge clk);
    chk(int'(xfer_count) == held, "R10", "xfer_count held", int'(xfer_count), held);
    chk(!busy, "R2", "busy after done", int'(busy), 0);
  endtask

  function automatic logic [N-1:0] rand_mask(int kind);
    logic [N-1:0] m;
    case (kind)
      0: m = N'($urandom);
      1: m = '1;
      2: m = N'(1) << $urandom_range(0, N - 1);
      default: m = N'($urandom) & N'($urandom) & N'($urandom);
    endcase
    return m;
  endfunction

  initial begin
    #(20 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !issue_valid && !done, "R1", "control outputs after reset",
        int'({busy, issue_valid, done}), 0);
    chk(xfer_count == '0, "R1", "count after reset", int'(xfer_count), 0);

    run_op(16, 16'hA5C3, '1, 1, 1, 8, 40, 0);            // compress
    run_op(12, '1, 16'h0F0F, 1, 1, 20, 60, 0);           // expand
    run_op(8, '1, '1, 0, 1, 3, 32, 0);                   // splat (R5)
    run_op(10, 16'h0000, 16'h0020, 0, 1, 11, 50, 0);     // insert
    run_op(12, 16'h0200, 16'h0000, 1, 0, 16, 90, 0);     // select (R6)
    run_op(0, '1, '1, 1, 1, 0, 0, 0);                    // VL zero (R8)
    run_op(16, 16'h0000, '1, 1, 1, 4, 4, 0);             // empty source mask (R8)
    run_op(8, '1, '1, 1, 1, 124, 126, 0);                // register wrap
    run_op(9, 16'h1234, 16'hFF00, 1, 1, 2, 70, 1);       // start ignored while busy (R2)
    run_op(16, 16'h8001, 16'h8001, 1, 1, 0, 100, 0);     // extreme bits

    for (int k = 0; k < 120; k++) begin
      run_op($urandom_range(0, N), rand_mask($urandom_range(0, 3)),
             rand_mask($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
             $urandom_range(0, (1 << RW) - 1), $urandom_range(0, (1 << RW) - 1),
             (k % 17) == 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule